// File: doc/BRIEF.md
# DMA Address Translation Unit

This block turns bus addresses issued by DMA masters into physical memory addresses. Software programs two 64-bit registers through a small register port: a control word and the base address of a translation table held in system memory. The control word enables translation, picks the page granularity used to index the table, and sets the table size. When translation is off, every address comes back unchanged with write permission. When it is on, the unit works out which table entry covers the address, fetches that 8-byte entry with a single read on its memory master port, and decodes it into a physical address, a write-permission flag or a fault.

One translation is handled at a time. A request is accepted with a valid/ready handshake. The memory read uses the same handshake, with the data returned later on a separate valid strobe. The result appears as a one-cycle response pulse. Each table entry picks its own page size, 8 KiB or 64 KiB, whatever indexing mode the table uses.

Top module: `dma_xlate_top`

## Requirements
- R1: After a synchronous active-low reset, the control and base registers read as zero, `req_ready` is high, and `mem_req_valid` and `rsp_valid` are low.
- R2: A 64-bit access (`reg_half`=0) to word index 0 reads or writes the whole control register, and one to word index 2 the whole base register. A write to word index 4 or 5 (flush) changes neither register, and reading it returns zero.
- R3: A 32-bit access (`reg_half`=1) at an even word index (0 or 2) targets bits 63:32 of the register, and one at the odd index (1 or 3) targets bits 31:0. Write data is taken from `reg_wdata[31:0]`, the other half is kept, and reads return the half zero-extended.
- R4: With control bit 0 clear, an accepted request yields `rsp_valid` on the next cycle with `rsp_paddr` equal to the request address, `rsp_writable`=1 and `rsp_fault`=0. No memory read is issued, whatever the other control bits hold.
- R5: With control bit 0 set and control bit 2 clear, the entry is read from base + 8 × addr[22+S:13], where S is control bits 18:16 (0 to 7). Address bits above 22+S have no effect.
- R6: With control bits 0 and 2 set and S from 0 to 5, the entry is read from base + 8 × addr[25+S:16].
- R7: With control bits 0 and 2 set and S equal to 6 or 7, an accepted request faults on the next cycle and no memory read is issued.
- R8: The entry is big-endian. Byte lane k of `mem_rsp_data` (bits 8k+7:8k) carries the byte at entry address + k, so entry bits 63:56 come from lane 0.
- R9: An entry whose bit 63 is clear produces a fault.
- R10: A valid entry with bit 61 clear maps an 8 KiB page, giving `rsp_paddr` = {entry[40:13], addr[12:0]}. With bit 61 set it maps a 64 KiB page, giving {entry[40:16], addr[15:0]}. Entry bits above 40 never reach the physical address.
- R11: For a valid entry, `rsp_writable` equals entry bit 1.
- R12: `req_ready` stays low from acceptance until the response cycle has passed. `mem_req_valid` holds with a stable address until `mem_req_ready`. `rsp_valid` rises the cycle after the one in which `mem_rsp_valid` is sampled.
- R13: A faulting response carries `rsp_paddr`=0 and `rsp_writable`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_half | input | 1 | 1 = 32-bit half access, 0 = 64-bit access |
| reg_addr | input | 3 | Register word index (byte offset bits 4:2) |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational from `reg_addr` and `reg_half` |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Unit idle, request accepted when valid |
| req_addr | input | 64 | DMA bus address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 64 | Translated physical address |
| rsp_writable | output | 1 | Write permission for the page |
| rsp_fault | output | 1 | Translation failed |
| mem_req_valid | output | 1 | Table entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry data, byte lane k = byte at address + k |

## Verification
Pass-through and bad-size requests give their response one cycle after acceptance. A fetch raises `mem_req_valid` one cycle after acceptance and holds it for as many cycles as `mem_req_ready` is withheld. The response then follows one cycle after the entry data strobe. The bench's behavioural model advances on each rising edge from the inputs the bench drove, and outputs are compared with it on every falling edge, so each result is checked in exactly the cycle it is due. Directed scenarios also check the entry address in the first issue cycle and the hand-computed response in the response cycle, with varied ready and data delays.

// File: rtl/xlate_pkg.sv
// Shared constants and types for the DMA address translation unit.
// Assumes 64-bit registers, 64-bit bus addresses and 8-byte table entries.
package xlate_pkg;
    localparam int unsigned WORD_W   = 64;
    localparam int unsigned HALF_W   = 32;
    localparam int unsigned REG_AW   = 3;   // word index, byte offset bits 4:2
    localparam int unsigned NREG     = 2;   // control, base
    localparam int unsigned ENTRY_B  = 8;   // bytes per table entry
    localparam int unsigned ENTRY_SH = 3;   // log2(ENTRY_B)

    // Register selectors (word index bits 2:1)
    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_BASE  = 2'd1;
    localparam logic [1:0] SEL_FLUSH = 2'd2;

    // Control word fields
    localparam int unsigned C_EN    = 0;
    localparam int unsigned C_WIDE  = 2;
    localparam int unsigned C_SZ_LO = 16;
    localparam int unsigned C_SZ_W  = 3;

    // Entry fields
    localparam int unsigned E_VALID = 63;
    localparam int unsigned E_BIG   = 61;
    localparam int unsigned E_WR    = 1;

    // Page shifts and index geometry
    localparam int unsigned SMALL_SH   = 13;
    localparam int unsigned LARGE_SH   = 16;
    localparam int unsigned IDX_BITS0  = 10;  // index width at size code 0
    localparam int unsigned LARGE_MAXC = 5;   // largest legal size code, 64K mode

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_RESP
    } xl_state_e;
endpackage

// File: rtl/xlate_regs.sv
// Register file: control and table base, each 64 bits, reachable as one
// 64-bit word or as two 32-bit halves (even index = upper half).
// Assumes a write and a read never need the same cycle's new value.
module xlate_regs
    import xlate_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic                half,
    input  logic [REG_AW-1:0]   addr,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   rdata,
    output logic                ctrl_en,
    output logic                ctrl_wide,
    output logic [C_SZ_W-1:0]   ctrl_size,
    output logic [WORD_W-1:0]   base
);
    logic [1:0] sel;
    logic       low_half;
    logic [WORD_W-1:0] full;

    assign sel      = addr[REG_AW-1:1];
    assign low_half = addr[0];

    // Merge new write data into an existing register value
    function automatic logic [WORD_W-1:0] merge(input logic [WORD_W-1:0] old,
                                                 input logic [WORD_W-1:0] nw,
                                                 input logic hf, input logic lo);
        if (!hf)
            return nw;
        else if (lo)
            return {old[WORD_W-1:HALF_W], nw[HALF_W-1:0]};
        else
            return {nw[HALF_W-1:0], old[HALF_W-1:0]};
    endfunction

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            logic [WORD_W-1:0] q;
            // Hold one register; update when its selector is written
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (we && sel == 2'(g))
                    q <= merge(q, wdata, half, low_half);
            end
        end
    endgenerate

    // Read mux: pick the register, then the requested view
    always_comb begin
        case (sel)
            SEL_CTRL: full = g_reg[0].q;
            SEL_BASE: full = g_reg[1].q;
            default:  full = '0;
        endcase
        if (!half)
            rdata = full;
        else if (low_half)
            rdata = {{HALF_W{1'b0}}, full[HALF_W-1:0]};
        else
            rdata = {{HALF_W{1'b0}}, full[WORD_W-1:HALF_W]};
    end

    assign ctrl_en   = g_reg[0].q[C_EN];
    assign ctrl_wide = g_reg[0].q[C_WIDE];
    assign ctrl_size = g_reg[0].q[C_SZ_LO +: C_SZ_W];
    assign base      = g_reg[1].q;

    AST_FLUSH_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_FLUSH) |=> ($stable(g_reg[0].q) && $stable(g_reg[1].q))); // R2
endmodule

// File: rtl/xlate_index.sv
// Table index unit: from a bus address, the page-size mode and the size code,
// forms the byte address of the covering entry and flags illegal size codes.
// Purely combinational; assumes base is 8-byte aligned by software.
module xlate_index
    import xlate_pkg::*;
(
    input  logic [WORD_W-1:0]  addr,
    input  logic               wide,
    input  logic [C_SZ_W-1:0]  size,
    input  logic [WORD_W-1:0]  base,
    output logic [WORD_W-1:0]  tbl_addr,
    output logic               size_bad
);
    localparam int unsigned SMALL_TOP0 = SMALL_SH + IDX_BITS0;
    localparam int unsigned LARGE_TOP0 = LARGE_SH + IDX_BITS0;

    logic [6:0]        span;
    logic [5:0]        low;
    logic [WORD_W-1:0] window;
    logic [WORD_W-1:0] idx;

    // Window out the index field and scale it to an entry byte offset
    always_comb begin
        span     = 7'(wide ? LARGE_TOP0 : SMALL_TOP0) + {4'd0, size};
        low      = 6'(wide ? LARGE_SH : SMALL_SH);
        window   = addr & ((64'd1 << span) - 64'd1);
        idx      = window >> low;
        tbl_addr = base + (idx << ENTRY_SH);
        size_bad = wide && (size > C_SZ_W'(LARGE_MAXC));
    end
endmodule

// File: rtl/xlate_ctrl.sv
// Sequencer: accepts one request, decides pass-through, size fault or fetch,
// issues the entry read, decodes the big-endian entry and pulses a response.
// Assumes the memory returns exactly one data strobe per accepted read.
module xlate_ctrl
    import xlate_pkg::*;
#(
    parameter int unsigned PA_MSB = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               size_bad,
    input  logic [WORD_W-1:0]  tbl_addr,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [WORD_W-1:0]  req_addr,
    output logic               rsp_valid,
    output logic [WORD_W-1:0]  rsp_paddr,
    output logic               rsp_writable,
    output logic               rsp_fault,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [WORD_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [WORD_W-1:0]  mem_rsp_data
);
    localparam logic [WORD_W-1:0] PA_MASK    = (64'd1 << (PA_MSB + 1)) - 64'd1;
    localparam logic [WORD_W-1:0] SMALL_MASK = (64'd1 << SMALL_SH) - 64'd1;
    localparam logic [WORD_W-1:0] LARGE_MASK = (64'd1 << LARGE_SH) - 64'd1;

    xl_state_e         state_q;
    logic [WORD_W-1:0] addr_q, tbl_q, paddr_q;
    logic              wr_q, fault_q;
    logic [WORD_W-1:0] entry, pg_mask, dec_paddr;

    // Byte lane k holds the byte at entry address + k: reverse into a word
    generate
        for (genvar b = 0; b < ENTRY_B; b++) begin : g_lane
            assign entry[WORD_W-1-8*b -: 8] = mem_rsp_data[8*b +: 8];
        end
    endgenerate

    // Entry decode: page frame from the entry, page offset from the address
    always_comb begin
        pg_mask   = entry[E_BIG] ? LARGE_MASK : SMALL_MASK;
        dec_paddr = (entry & PA_MASK & ~pg_mask) | (addr_q & pg_mask);
    end

    // Main sequence and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            tbl_q   <= '0;
            paddr_q <= '0;
            wr_q    <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    addr_q <= req_addr;
                    if (!en) begin
                        paddr_q <= req_addr;
                        wr_q    <= 1'b1;
                        fault_q <= 1'b0;
                        state_q <= ST_RESP;
                    end else if (size_bad) begin
                        paddr_q <= '0;
                        wr_q    <= 1'b0;
                        fault_q <= 1'b1;
                        state_q <= ST_RESP;
                    end else begin
                        tbl_q   <= tbl_addr;
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: if (mem_req_ready) state_q <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    if (entry[E_VALID]) begin
                        paddr_q <= dec_paddr;
                        wr_q    <= entry[E_WR];
                        fault_q <= 1'b0;
                    end else begin
                        paddr_q <= '0;
                        wr_q    <= 1'b0;
                        fault_q <= 1'b1;
                    end
                    state_q <= ST_RESP;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_ISSUE);
    assign mem_req_addr  = tbl_q;
    assign rsp_valid     = (state_q == ST_RESP);
    assign rsp_paddr     = paddr_q;
    assign rsp_writable  = wr_q;
    assign rsp_fault     = fault_q;

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R12
    AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R12
    AST_RSP_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && mem_rsp_valid) |=> rsp_valid); // R12
    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && !rsp_writable)); // R13
    AST_BYPASS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !en) |=> (rsp_valid && rsp_writable && !rsp_fault)); // R4
    AST_BADSIZE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && en && size_bad) |=> (rsp_valid && rsp_fault)); // R7
endmodule

// File: rtl/dma_xlate_top.sv
// DMA address translation unit top: register file, index unit and sequencer.
// Assumes a single requester and a memory port that returns data in order.
module dma_xlate_top
    import xlate_pkg::*;
#(
    parameter int unsigned PA_MSB = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic                 reg_half,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [WORD_W-1:0]    req_addr,
    output logic                 rsp_valid,
    output logic [WORD_W-1:0]    rsp_paddr,
    output logic                 rsp_writable,
    output logic                 rsp_fault,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [WORD_W-1:0]    mem_req_addr,
    input  logic                 mem_rsp_valid,
    input  logic [WORD_W-1:0]    mem_rsp_data
);
    logic               c_en, c_wide, sz_bad;
    logic [C_SZ_W-1:0]  c_size;
    logic [WORD_W-1:0]  t_base, t_addr;

    xlate_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .half(reg_half),
        .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .ctrl_en(c_en), .ctrl_wide(c_wide), .ctrl_size(c_size), .base(t_base)
    );

    xlate_index u_index (
        .addr(req_addr), .wide(c_wide), .size(c_size), .base(t_base),
        .tbl_addr(t_addr), .size_bad(sz_bad)
    );

    xlate_ctrl #(.PA_MSB(PA_MSB)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(c_en), .size_bad(sz_bad), .tbl_addr(t_addr),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_writable(rsp_writable),
        .rsp_fault(rsp_fault), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );
endmodule

// File: tb/sim_dma_xlate_top.sv
`timescale 1ns/1ps
module sim_dma_xlate_top;
    logic        clk = 0, rst_n = 0;
    logic        reg_we = 0, reg_half = 0;
    logic [2:0]  reg_addr = 0;
    logic [63:0] reg_wdata = 0, req_addr = 0, mem_rsp_data = 0;
    logic        req_valid = 0, mem_req_ready = 0, mem_rsp_valid = 0;
    logic [63:0] reg_rdata, rsp_paddr, mem_req_addr;
    logic        req_ready, rsp_valid, rsp_writable, rsp_fault, mem_req_valid;

    int    n_chk = 0, n_err = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    dma_xlate_top u0 (.*);

    // ---------------- behavioural reference model ----------------
    int          m_st = 0;   // 0 idle, 1 issuing read, 2 awaiting data, 3 responding
    logic [63:0] m_ctrl = 0, m_base = 0, m_addr = 0, m_tbl = 0, m_pa = 0;
    bit          m_wr = 0, m_f = 0;

    function automatic logic [63:0] lanes_to_word(input logic [63:0] l);
        logic [63:0] w;
        for (int k = 0; k < 8; k++) w[63-8*k -: 8] = l[8*k +: 8];
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_ctrl = 0; m_base = 0; m_pa = 0; m_wr = 0; m_f = 0; m_tbl = 0;
        end else begin
            int sz, sh, pg;
            logic [63:0] e;
            sz = int'((m_ctrl >> 16) & 7);
            case (m_st)
                0: if (req_valid) begin
                    m_addr = req_addr;
                    if (!m_ctrl[0]) begin m_pa = req_addr; m_wr = 1; m_f = 0; m_st = 3; end
                    else if (m_ctrl[2] && sz > 5) begin m_pa = 0; m_wr = 0; m_f = 1; m_st = 3; end
                    else begin
                        sh = m_ctrl[2] ? 16 : 13;
                        m_tbl = m_base + (((req_addr >> sh) & ((64'd1 << (10 + sz)) - 1)) * 8);
                        m_st = 1;
                    end
                end
                1: if (mem_req_ready) m_st = 2;
                2: if (mem_rsp_valid) begin
                    e = lanes_to_word(mem_rsp_data);
                    if (!e[63]) begin m_pa = 0; m_wr = 0; m_f = 1; end
                    else begin
                        pg = e[61] ? 16 : 13;
                        m_pa = (((e & ((64'd1 << 41) - 1)) >> pg) << pg) | (m_addr & ((64'd1 << pg) - 1));
                        m_wr = e[1]; m_f = 0;
                    end
                    m_st = 3;
                end
                default: m_st = 0;
            endcase
            if (reg_we) begin
                case (reg_addr)
                    3'd0: m_ctrl = reg_half ? {reg_wdata[31:0], m_ctrl[31:0]} : reg_wdata;
                    3'd1: m_ctrl = reg_half ? {m_ctrl[63:32], reg_wdata[31:0]} : reg_wdata;
                    3'd2: m_base = reg_half ? {reg_wdata[31:0], m_base[31:0]} : reg_wdata;
                    3'd3: m_base = reg_half ? {m_base[63:32], reg_wdata[31:0]} : reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", rq, what, act, exp, $time);
        end
    endtask

    // Compare every cycle against the model, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(req_ready == (m_st == 0), cur_req, "req_ready", 64'(req_ready), 64'(m_st == 0));
            chk(mem_req_valid == (m_st == 1), cur_req, "mem_req_valid", 64'(mem_req_valid), 64'(m_st == 1));
            chk(rsp_valid == (m_st == 3), cur_req, "rsp_valid", 64'(rsp_valid), 64'(m_st == 3));
            if (m_st == 1) chk(mem_req_addr == m_tbl, cur_req, "mem_req_addr", mem_req_addr, m_tbl);
            if (m_st == 3) begin
                chk(rsp_paddr == m_pa, cur_req, "rsp_paddr", rsp_paddr, m_pa);
                chk(rsp_writable == m_wr, cur_req, "rsp_writable", 64'(rsp_writable), 64'(m_wr));
                chk(rsp_fault == m_f, cur_req, "rsp_fault", 64'(rsp_fault), 64'(m_f));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic reg_write(input logic [2:0] a, input bit h, input logic [63:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_half = h; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic reg_check(input logic [2:0] a, input bit h, input logic [63:0] exp, input string rq);
        @(negedge clk); reg_addr = a; reg_half = h; #1;
        chk(reg_rdata == exp, rq, "reg_rdata", reg_rdata, exp);
    endtask

    function automatic logic [63:0] word_to_lanes(input logic [63:0] w);
        logic [63:0] l;
        for (int k = 0; k < 8; k++) l[8*k +: 8] = w[63-8*k -: 8];
        return l;
    endfunction

    // One translation; expected entry address and response computed by hand
    task automatic xlate(input logic [63:0] a, input logic [63:0] e, input int rl, input int dl,
                         input logic [63:0] exp_tbl, input logic [63:0] exp_pa,
                         input bit exp_w, input bit exp_f, input string rq);
        bit fetch;
        cur_req = rq;
        fetch = m_ctrl[0] && !(m_ctrl[2] && ((m_ctrl >> 16) & 7) > 5);
        @(negedge clk); req_valid = 1; req_addr = a;
        @(negedge clk); req_valid = 0;
        if (fetch) begin
            chk(mem_req_valid && mem_req_addr == exp_tbl, rq, "entry address", mem_req_addr, exp_tbl);
            repeat (rl) @(negedge clk);
            mem_req_ready = 1;
            @(negedge clk); mem_req_ready = 0;
            repeat (dl) @(negedge clk);
            mem_rsp_valid = 1; mem_rsp_data = word_to_lanes(e);
            @(negedge clk); mem_rsp_valid = 0;
        end else begin
            chk(!mem_req_valid, rq, "no memory read", 64'(mem_req_valid), 64'd0);
        end
        chk(rsp_valid == 1, rq, "response due", 64'(rsp_valid), 64'd1);
        chk(rsp_paddr == exp_pa, rq, "paddr", rsp_paddr, exp_pa);
        chk(rsp_writable == exp_w, rq, "writable", 64'(rsp_writable), 64'(exp_w));
        chk(rsp_fault == exp_f, rq, "fault", 64'(rsp_fault), 64'(exp_f));
        @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1: reset values
        reg_check(3'd0, 0, 64'd0, "R1");
        reg_check(3'd2, 0, 64'd0, "R1");
        // R2: whole-word access and flush
        cur_req = "R2";
        reg_write(3'd2, 0, 64'h1122_3344_5566_7788);
        reg_check(3'd2, 0, 64'h1122_3344_5566_7788, "R2");
        reg_write(3'd0, 0, 64'h0000_0000_0003_0004);
        reg_write(3'd4, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_write(3'd5, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_check(3'd0, 0, 64'h0000_0000_0003_0004, "R2");
        reg_check(3'd2, 0, 64'h1122_3344_5566_7788, "R2");
        reg_check(3'd4, 0, 64'd0, "R2");
        // R3: half accesses
        cur_req = "R3";
        reg_write(3'd2, 1, 64'h0000_0000_AAAA_BBBB);
        reg_check(3'd2, 0, 64'hAAAA_BBBB_5566_7788, "R3");
        reg_write(3'd3, 1, 64'h9999_9999_CCCC_DDDD);
        reg_check(3'd2, 0, 64'hAAAA_BBBB_CCCC_DDDD, "R3");
        reg_check(3'd2, 1, 64'h0000_0000_AAAA_BBBB, "R3");
        reg_check(3'd3, 1, 64'h0000_0000_CCCC_DDDD, "R3");
        reg_write(3'd1, 1, 64'h0000_0000_0001_0000);
        reg_check(3'd0, 0, 64'h0000_0000_0001_0000, "R3");
        // R4: pass-through, other control bits set but enable clear
        reg_write(3'd0, 0, 64'h0000_0000_0006_0004);
        xlate(64'h0123_4567_89AB_CDEF, 64'd0, 0, 0, 64'd0, 64'h0123_4567_89AB_CDEF, 1, 0, "R4");
        // R5 R8 R10 R11: 8K indexing, size 0, bit 23 outside the index
        reg_write(3'd2, 0, 64'h0000_0000_4000_0000);
        reg_write(3'd0, 0, 64'h0000_0000_0000_0001);
        xlate(64'h0000_0000_00D5_2345, 64'h8000_01AB_CDEF_E002, 0, 0,
              64'h0000_0000_4000_1548, 64'h0000_01AB_CDEF_E345, 1, 0, "R5");
        // R5 R10 R11: size 7, entry bits above 40 dropped, read-only
        reg_write(3'd2, 0, 64'h0000_0000_0000_1000);
        reg_write(3'd0, 0, 64'h0000_0000_0007_0001);
        xlate(64'h0000_0000_3FFF_EABC, 64'h8100_0200_0000_4000, 1, 2,
              64'h0000_0000_0010_0FF8, 64'h0000_0000_0000_4ABC, 0, 0, "R10");
        // R6: 64K indexing, size 0, 64K page writable
        reg_write(3'd2, 0, 64'h0000_0002_0000_0000);
        reg_write(3'd0, 0, 64'h0000_0000_0000_0005);
        xlate(64'h0000_0000_03FF_1234, 64'hA000_0123_4567_0002, 0, 0,
              64'h0000_0002_0000_1FF8, 64'h0000_0123_4567_1234, 1, 0, "R6");
        // R6 R11: size 5, bit 31 outside the index, entry picks an 8K page
        reg_write(3'd0, 0, 64'h0000_0000_0005_0005);
        xlate(64'h0000_0000_FFFF_BEEF, 64'h8000_0000_0001_E000, 0, 1,
              64'h0000_0002_0003_FFF8, 64'h0000_0000_0001_FEEF, 0, 0, "R11");
        // R7 R13: illegal size codes in 64K mode
        reg_write(3'd0, 0, 64'h0000_0000_0006_0005);
        xlate(64'h0000_0000_1234_5678, 64'd0, 0, 0, 64'd0, 64'd0, 0, 1, "R7");
        reg_write(3'd0, 0, 64'h0000_0000_0007_0005);
        xlate(64'h0000_0000_1234_5678, 64'd0, 0, 0, 64'd0, 64'd0, 0, 1, "R13");
        // R9: valid bit clear, other fields set
        reg_write(3'd2, 0, 64'h0000_0000_0000_1000);
        reg_write(3'd0, 0, 64'h0000_0000_0002_0001);
        xlate(64'h0000_0000_0000_4000, 64'h2000_01FF_FFFF_E002, 0, 0,
              64'h0000_0000_0000_1010, 64'd0, 0, 1, "R9");
        // R12: long ready and data delays
        reg_write(3'd2, 0, 64'h0000_0000_4000_0000);
        reg_write(3'd0, 0, 64'h0000_0000_0000_0001);
        xlate(64'h0000_0000_00D5_2345, 64'h8000_01AB_CDEF_E002, 3, 4,
              64'h0000_0000_4000_1548, 64'h0000_01AB_CDEF_E345, 1, 0, "R12");
        // R8: byte-order sensitivity, entry with distinct bytes
        xlate(64'h0000_0000_0000_0010, 64'h8000_0001_0203_6002, 2, 0,
              64'h0000_0000_4000_0000, 64'h0000_0001_0203_6010, 1, 0, "R8");
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule